// File: doc/BRIEF.md
# Two-Digit BCD Calendar Year Register

This block keeps the year of a real-time clock calendar as two packed BCD digits, covering 00 to 99. A one-cycle carry pulse from the month stage advances the year by one. Ninety-nine is followed by zero zero. Software reads the value at any time on a plain data output. It may load a new value, but only while the clock's run control is off. A combinational leap flag goes to the day-of-month rollover logic.

A small control machine has two named states. `MODE_HALT` accepts loads and ignores carries. `MODE_COUNT` accepts carries and ignores loads. The machine registers the run input, so it takes the transition `HALT->COUNT` one cycle after `run_i` rises. It takes `COUNT->HALT` one cycle after `run_i` falls. Reset returns the control machine to `MODE_HALT`. The year digits have no reset, so the stored year survives every reset. A loaded value that is not BCD, or is out of range, counts in an undefined way and is not corrected.

Top module: `rtc_year_reg`

## Requirements
- R1: `year_o[7:4]` holds the tens digit and `year_o[3:0]` holds the units digit, both in BCD.
- R2: In `MODE_COUNT`, a cycle with `month_carry_i` high adds one year, and the result is visible on the next cycle. A units digit of 9 becomes 0, and the tens digit goes up by one.
- R3: A count from 99 gives 00.
- R4: `leap_o` is 1 exactly when the stored year is divisible by 4, with 00 counted as a leap year. For BCD digits, this holds when the units digit is 0, 4 or 8 and the tens digit is even, or when the units digit is 2 or 6 and the tens digit is odd.
- R5: In `MODE_HALT`, a cycle with `wr_en_i` high loads `wr_data_i`, and the new value is visible on the next cycle.
- R6: In `MODE_COUNT`, `wr_en_i` has no effect on the stored year.
- R7: In `MODE_HALT`, `month_carry_i` has no effect on the stored year.
- R8: The mode follows `run_i` with one cycle of delay, and reset forces `MODE_HALT`.
- R9: Asserting or releasing `rst_n` does not change the stored year.
- R10: In `MODE_COUNT`, if a write and a carry arrive in the same cycle, the carry advances the year and the write is dropped. In `MODE_HALT`, if both arrive together, the write is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset for the control machine only |
| run_i | input | 1 | Run control: 1 counts, 0 halts and permits loads |
| month_carry_i | input | 1 | One-cycle pulse from the month counter |
| wr_en_i | input | 1 | Load strobe from the register bus |
| wr_data_i | input | 8 | Value to load, BCD |
| year_o | output | 8 | Stored year, BCD |
| leap_o | output | 1 | Leap-year indication for the stored year |

## Verification
The bench targets several corner cases:
- **Digit ripple at x9 and the wrap from 99.** A design that forgets the ripple produces a units digit of A. A design that forgets the wrap leaves a tens digit of A.
- **Leap flag at 00 and at years such as 12, 16 and 96.** A decoder that tests only the units bits would flag 10 or miss 12.
- **Loads and carries in the wrong mode, on the exact cycles around a `run_i` change.** A design that gates without the one-cycle mode delay, or lets a write through while counting, shows a stored value that differs from the model.
- **Reset pulse retention.** A reset pulse must leave the year unchanged, so a design that clears the year during reset would read back 00.

// File: rtl/rtc_year_pkg.sv
package rtc_year_pkg;
    typedef enum logic {
        MODE_HALT  = 1'b0,
        MODE_COUNT = 1'b1
    } year_mode_e;

    function automatic logic [7:0] bcd_year_next(input logic [7:0] y);
        logic [3:0] lo;
        logic [3:0] hi;
        lo = y[3:0];
        hi = y[7:4];
        if (lo == 4'd9) begin
            lo = 4'd0;
            hi = (hi == 4'd9) ? 4'd0 : hi + 4'd1;
        end else begin
            lo = lo + 4'd1;
        end
        return {hi, lo};
    endfunction
endpackage

// File: rtl/rtc_year_ctrl.sv
module rtc_year_ctrl
    import rtc_year_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic carry_i,
    input  logic wr_en_i,
    output logic load_o,
    output logic step_o,
    output logic counting_o
);
    year_mode_e mode_q;
    year_mode_e mode_d;

    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_HALT:  if (run_i)  mode_d = MODE_COUNT;
            MODE_COUNT: if (!run_i) mode_d = MODE_HALT;
            default:    mode_d = MODE_HALT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= MODE_HALT;
        else        mode_q <= mode_d;
    end

    always_comb begin
        load_o     = 1'b0;
        step_o     = 1'b0;
        counting_o = 1'b0;
        unique case (mode_q)
            MODE_HALT:  load_o = wr_en_i;
            MODE_COUNT: begin
                step_o     = carry_i;
                counting_o = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/rtc_bcd_digit.sv
module rtc_bcd_digit #(
    parameter int DIGIT_W = 4
) (
    input  logic               clk,
    input  logic               load_i,
    input  logic [DIGIT_W-1:0] load_val_i,
    input  logic               step_i,
    output logic [DIGIT_W-1:0] val_o
);
    localparam logic [DIGIT_W-1:0] TOP = DIGIT_W'(9);

    logic [DIGIT_W-1:0] val_q;

    always_ff @(posedge clk) begin
        if (load_i)
            val_q <= load_val_i;
        else if (step_i)
            val_q <= (val_q == TOP) ? '0 : val_q + DIGIT_W'(1);
    end

    assign val_o = val_q;
endmodule

// File: rtl/rtc_leap_detect.sv
module rtc_leap_detect #(
    parameter int DIGIT_W = 4
) (
    input  logic [DIGIT_W-1:0] units_i,
    input  logic               tens_odd_i,
    output logic               leap_o
);
    logic mult4_even;
    logic mult4_odd;

    always_comb begin
        mult4_even = (units_i == DIGIT_W'(0)) || (units_i == DIGIT_W'(4)) ||
                     (units_i == DIGIT_W'(8));
        mult4_odd  = (units_i == DIGIT_W'(2)) || (units_i == DIGIT_W'(6));
        leap_o     = tens_odd_i ? mult4_odd : mult4_even;
    end
endmodule

// File: rtl/rtc_year_reg.sv
module rtc_year_reg #(
    parameter int DIGIT_W    = 4,
    parameter int NUM_DIGITS = 2,
    localparam int YEAR_W    = DIGIT_W * NUM_DIGITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              month_carry_i,
    input  logic              wr_en_i,
    input  logic [YEAR_W-1:0] wr_data_i,
    output logic [YEAR_W-1:0] year_o,
    output logic              leap_o
);
    logic load_en;
    logic step_en;
    logic counting;
    logic [NUM_DIGITS-1:0] step_vec;
    logic [DIGIT_W-1:0]    dig [NUM_DIGITS];

    rtc_year_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (run_i),
        .carry_i    (month_carry_i),
        .wr_en_i    (wr_en_i),
        .load_o     (load_en),
        .step_o     (step_en),
        .counting_o (counting)
    );

    assign step_vec[0] = step_en;

    for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_digit
        if (g > 0) begin : g_ripple
            assign step_vec[g] = step_vec[g-1] && (dig[g-1] == DIGIT_W'(9));
        end
        rtc_bcd_digit #(.DIGIT_W(DIGIT_W)) u_dig (
            .clk        (clk),
            .load_i     (load_en),
            .load_val_i (wr_data_i[g*DIGIT_W +: DIGIT_W]),
            .step_i     (step_vec[g]),
            .val_o      (dig[g])
        );
        assign year_o[g*DIGIT_W +: DIGIT_W] = dig[g];
    end

    rtc_leap_detect #(.DIGIT_W(DIGIT_W)) u_leap (
        .units_i    (dig[0]),
        .tens_odd_i (dig[1][0]),
        .leap_o     (leap_o)
    );
endmodule

// File: rtl/rtc_year_chk.sv
module rtc_year_chk
    import rtc_year_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       run_i,
    input logic       counting,
    input logic       month_carry_i,
    input logic       wr_en_i,
    input logic [7:0] wr_data_i,
    input logic [7:0] year_o,
    input logic       leap_o
);
    logic valid_bcd;
    logic [6:0] dec_val;
    assign valid_bcd = (year_o[7:4] <= 4'd9) && (year_o[3:0] <= 4'd9);
    assign dec_val   = 7'(year_o[7:4]) * 7'd10 + 7'(year_o[3:0]);

    // R2 R3 R10: counting with a carry advances the year
    a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (counting && month_carry_i && valid_bcd) |=> (year_o == bcd_year_next($past(year_o))));

    // R6: write while counting is dropped
    a_r6_no_load_running: assert property (@(posedge clk) disable iff (!rst_n)
        (counting && !month_carry_i) |=> $stable(year_o));

    // R5 R10: load while halted
    a_r5_load_halted: assert property (@(posedge clk) disable iff (!rst_n)
        (!counting && wr_en_i) |=> (year_o == $past(wr_data_i)));

    // R7: carry while halted is ignored
    a_r7_hold_halted: assert property (@(posedge clk) disable iff (!rst_n)
        (!counting && !wr_en_i) |=> $stable(year_o));

    // R8: mode follows run with one cycle delay
    a_r8_mode_follows: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (counting == $past(run_i)));

    // R4: leap flag matches divisibility by four
    a_r4_leap: assert property (@(posedge clk) disable iff (!rst_n)
        valid_bcd |-> (leap_o == (dec_val[1:0] == 2'b00)));
endmodule

bind rtc_year_reg rtc_year_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .run_i         (run_i),
    .counting      (counting),
    .month_carry_i (month_carry_i),
    .wr_en_i       (wr_en_i),
    .wr_data_i     (wr_data_i),
    .year_o        (year_o),
    .leap_o        (leap_o)
);

// File: tb/rtc_year_reg_test.sv
`timescale 1ns/1ps
module rtc_year_reg_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run_i = 1'b0;
    logic       month_carry_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [7:0] wr_data_i = 8'h00;
    logic [7:0] year_o;
    logic       leap_o;

    int total = 0;
    int bad = 0;
    int model_year = 0;
    bit model_run = 1'b0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    rtc_year_reg uut (
        .clk(clk), .rst_n(rst_n), .run_i(run_i), .month_carry_i(month_carry_i),
        .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .year_o(year_o), .leap_o(leap_o)
    );

    function automatic logic [7:0] to_bcd(input int y);
        return {4'(y / 10), 4'(y % 10)};
    endfunction

    function automatic bit is_leap(input int y);
        return (y % 4) == 0;
    endfunction

    task automatic check(input string req, input int exp_year);
        total++;
        if (year_o !== to_bcd(exp_year)) begin
            bad++;
            $display("FAIL %s year actual=%h expected=%h", req, year_o, to_bcd(exp_year));
        end
        total++;
        if (leap_o !== is_leap(exp_year)) begin
            bad++;
            $display("FAIL %s leap actual=%b expected=%b", req, leap_o, is_leap(exp_year));
        end
    endtask

    // one cycle: drive at negedge, sample after the following posedge
    task automatic cycle(input bit wr, input logic [7:0] d, input bit cy, input bit run);
        @(negedge clk);
        wr_en_i = wr; wr_data_i = d; month_carry_i = cy; run_i = run;
        @(negedge clk);
        wr_en_i = 1'b0; month_carry_i = 1'b0;
    endtask

    task automatic set_run(input bit r);
        cycle(1'b0, 8'h00, 1'b0, r);
        model_run = r;
    endtask

    task automatic load(input int y, input string req);
        cycle(1'b1, to_bcd(y), 1'b0, 1'b0);
        model_year = y;
        check(req, model_year);
    endtask

    task automatic carry(input string req);
        cycle(1'b0, 8'h00, 1'b1, 1'b1);
        model_year = (model_year + 1) % 100;
        check(req, model_year);
    endtask

    initial begin
        #1_600_000;
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        // load during reset: mode is forced halt (R8)
        cycle(1'b1, 8'h37, 1'b0, 1'b0);
        model_year = 37;
        check("R8 R5 load under reset", 37);
        @(negedge clk); rst_n = 1'b1;
        check("R9 reset release keeps year", 37);
        check("R1 layout 37", 37);

        load(19, "R5 load 19");
        load(0,  "R4 leap at 00");
        load(10, "R4 non-leap 10");
        load(12, "R4 leap 12");
        load(96, "R4 leap 96");

        // halted carry ignored (R7)
        cycle(1'b0, 8'h00, 1'b1, 1'b0);
        check("R7 carry halted", 96);

        // halted write plus carry: write wins (R10)
        cycle(1'b1, to_bcd(48), 1'b1, 1'b0);
        model_year = 48;
        check("R10 halted write wins", 48);

        load(9, "R5 load 09");
        // run rises: this cycle still halted, a carry here is ignored (R8)
        cycle(1'b0, 8'h00, 1'b1, 1'b1);
        model_run = 1'b1;
        check("R8 carry on run edge ignored", 9);
        carry("R2 ripple 09->10");
        // write while counting ignored (R6)
        cycle(1'b1, 8'h55, 1'b0, 1'b1);
        check("R6 write running ignored", 10);
        // write plus carry while counting: carry wins (R10)
        cycle(1'b1, 8'h55, 1'b1, 1'b1);
        model_year = 11;
        check("R10 running carry wins", 11);

        // run falls: next cycle still counting (R8)
        cycle(1'b0, 8'h00, 1'b1, 1'b0);
        model_year = 12;
        check("R8 still counting on fall edge", 12);
        set_run(1'b0);
        check("R8 halted", 12);

        load(98, "R5 load 98");
        set_run(1'b1);
        carry("R2 98->99");
        carry("R3 wrap 99->00");
        check("R4 leap after wrap", 0);

        // reset pulse keeps year (R9)
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check("R9 during reset", 0);
        run_i = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        model_run = 1'b0;
        @(negedge clk);
        check("R9 after reset", 0);

        // constrained random mix
        for (int i = 0; i < 400; i++) begin
            int op;
            op = int'($urandom_range(0, 9));
            if (op < 2) begin
                set_run(!model_run);
                check("R8 random toggle", model_year);
            end else if (op < 5) begin
                int y;
                y = int'($urandom_range(0, 99));
                cycle(1'b1, to_bcd(y), 1'b0, model_run);
                if (!model_run) model_year = y;
                check(model_run ? "R6 random write" : "R5 random write", model_year);
            end else begin
                cycle(1'b0, 8'h00, 1'b1, model_run);
                if (model_run) model_year = (model_year + 1) % 100;
                check(model_run ? "R2 random carry" : "R7 random carry", model_year);
            end
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule